// File: doc/BRIEF.md
# Register Window Buffer Controller

This block keeps the bookkeeping for a register file used as a circular buffer of procedure windows. Every call asks for a window. The new window is placed at the tail of the buffer. If the registers still resident do not leave enough room, the block reports how many registers at the head must be written out to memory. It reports the smallest number that makes the window fit. A return frees the current window. If part of the caller's window had been written out earlier, the block reports how many registers must be brought back. Reloads therefore happen only when a chain of returns reaches a frame that is no longer fully present.

The block works in one of two modes, chosen by a parameter. In fixed mode every window has the same configured size. In variable mode each call supplies its own size. The buffer capacity is a parameter; typical values are 64, 96 or 128. The register contents, the memory traffic and the operand addressing inside a window all belong to the surrounding data path. Each request completes in one clock cycle, and its spill or reload amount appears combinationally in the same cycle as the request.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset, occupancy, depth and both running totals read zero, and no strobe or error flag is active.
- R2: An accepted call adds one frame to depth. Occupancy becomes the previous occupancy plus the window size, minus any spill.
- R3: When occupancy plus the window size exceeds the capacity, spill_valid is raised in the same cycle as the call. spill_count equals exactly that excess, and occupancy then equals the capacity. With no excess, spill_valid stays low and spill_count reads 0.
- R4: An accepted return removes the current frame. Depth drops by one and occupancy drops by that frame's size, before any reload.
- R5: On a return, reload_valid is raised only when the caller's frame is larger than the registers still resident. reload_count is the missing amount, and occupancy then equals the caller's frame size. Spill and reload are never reported in the same cycle.
- R6: total_spilled accumulates every spill_count, and total_reloaded accumulates every reload_count.
- R7: In fixed mode every call uses the configured window size, and call_size has no effect.
- R8: A call is rejected with call_err, and no state changes, in any of three cases: the window size is 0, the size exceeds the capacity, or the frame stack already holds its maximum number of frames.
- R9: A return while depth is 0 raises underflow_err and changes no state.
- R10: When call_req and ret_req are both high, the call is performed and the return is ignored.
- R11: Occupancy never exceeds the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Procedure call request |
| ret_req | input | 1 | Procedure return request |
| call_size | input | 8 | Window size for the call (variable mode) |
| spill_valid | output | 1 | Registers must be written out for this call |
| spill_count | output | 8 | Number of head registers to spill |
| reload_valid | output | 1 | Registers must be brought back for this return |
| reload_count | output | 8 | Number of caller registers to reload |
| call_err | output | 1 | Call rejected (zero size, oversize or stack full) |
| underflow_err | output | 1 | Return with no active frame |
| occupancy | output | 8 | Registers currently resident in the buffer |
| depth | output | 6 | Active frames |
| total_spilled | output | 32 | Running total of spilled registers |
| total_reloaded | output | 32 | Running total of reloaded registers |

## Verification
The bench goes after four kinds of case.

- Partial spills, where a call only just overflows the buffer. A design that spilled whole frames would report too large a count, and the occupancy would sag below the capacity.
- Returns that land on a frame that was partly written out. A design that reloaded eagerly, or reloaded the full frame, would show the wrong reload amount, and the later occupancy would differ.
- Rejected calls and returns. A design that recorded even part of a rejected request would show a changed depth or occupancy on the next cycle. This includes a call against a full frame stack.
- Simultaneous call and return. A design that let the return through would lose a frame.

A second instance in fixed mode gets the same stimulus with nonsense sizes, to show that call_size is ignored there.

// File: rtl/rwin_ctrl.sv
module rwin_ctrl #(
  parameter int CAPACITY    = 128,
  parameter bit FIXED_MODE  = 1'b0,
  parameter int FIXED_SIZE  = 8,
  parameter int STACK_DEPTH = 32,
  parameter int CNT_W       = 32,
  localparam int SZW = $clog2(CAPACITY + 1),
  localparam int DW  = $clog2(STACK_DEPTH + 1),
  localparam int PW  = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_req,
  input  logic             ret_req,
  input  logic [SZW-1:0]   call_size,
  output logic             spill_valid,
  output logic [SZW-1:0]   spill_count,
  output logic             reload_valid,
  output logic [SZW-1:0]   reload_count,
  output logic             call_err,
  output logic             underflow_err,
  output logic [SZW-1:0]   occupancy,
  output logic [DW-1:0]    depth,
  output logic [CNT_W-1:0] total_spilled,
  output logic [CNT_W-1:0] total_reloaded
);

  localparam logic [SZW-1:0] CAP_V   = CAPACITY[SZW-1:0];
  localparam logic [SZW-1:0] FIX_V   = FIXED_SIZE[SZW-1:0];
  localparam logic [DW-1:0]  FULL_V  = STACK_DEPTH[DW-1:0];
  localparam logic [DW-1:0]  ONE_D   = 1;
  localparam logic [PW-1:0]  ONE_P   = 1;

  logic [SZW-1:0] frames [STACK_DEPTH];
  logic [SZW-1:0] used;
  logic [DW-1:0]  dep;
  logic [PW-1:0]  top_p;
  logic [CNT_W-1:0] tot_sp, tot_rl;

  wire [SZW-1:0] win    = FIXED_MODE ? FIX_V : call_size;
  wire           call_ok = call_req && (win != '0) && (win <= CAP_V) && (dep != FULL_V);
  wire           ret_go  = ret_req && !call_req;
  wire           ret_ok  = ret_go && (dep != '0);

  wire [SZW-1:0] room    = CAP_V - used;
  wire [SZW-1:0] spill_n = (win > room) ? (win - room) : '0;
  wire [PW-1:0]  wr_p    = (dep == '0) ? '0 : top_p + ONE_P;

  wire [SZW-1:0] top_sz  = frames[top_p];
  wire [SZW-1:0] caller  = frames[top_p - ONE_P];
  wire [SZW-1:0] left    = used - top_sz;
  wire [SZW-1:0] rl_n    = ((dep > ONE_D) && (left < caller)) ? (caller - left) : '0;

  assign spill_valid    = call_ok && (spill_n != '0);
  assign spill_count    = spill_valid ? spill_n : '0;
  assign reload_valid   = ret_ok && (rl_n != '0);
  assign reload_count   = reload_valid ? rl_n : '0;
  assign call_err       = call_req && !call_ok;
  assign underflow_err  = ret_go && (dep == '0);
  assign occupancy      = used;
  assign depth          = dep;
  assign total_spilled  = tot_sp;
  assign total_reloaded = tot_rl;

  always_ff @(posedge clk) begin
    if (call_ok) frames[wr_p] <= win;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used   <= '0;
      dep    <= '0;
      top_p  <= '0;
      tot_sp <= '0;
      tot_rl <= '0;
    end else if (call_ok) begin
      used   <= used + win - spill_n;
      dep    <= dep + ONE_D;
      top_p  <= wr_p;
      tot_sp <= tot_sp + {{(CNT_W-SZW){1'b0}}, spill_n};
    end else if (ret_ok) begin
      used   <= left + rl_n;
      dep    <= dep - ONE_D;
      top_p  <= top_p - ONE_P;
      tot_rl <= tot_rl + {{(CNT_W-SZW){1'b0}}, rl_n};
    end
  end

endmodule

// File: rtl/rwin_ctrl_chk.sv
module rwin_ctrl_chk #(
  parameter int CAPACITY    = 128,
  parameter int STACK_DEPTH = 32,
  parameter int CNT_W       = 32,
  localparam int SZW = $clog2(CAPACITY + 1),
  localparam int DW  = $clog2(STACK_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             call_req,
  input logic             spill_valid,
  input logic [SZW-1:0]   spill_count,
  input logic             reload_valid,
  input logic [SZW-1:0]   reload_count,
  input logic             call_err,
  input logic             underflow_err,
  input logic [SZW-1:0]   occupancy,
  input logic [DW-1:0]    depth,
  input logic [CNT_W-1:0] total_spilled,
  input logic [CNT_W-1:0] total_reloaded
);

  localparam logic [SZW-1:0] CAP_V = CAPACITY[SZW-1:0];
  localparam logic [DW-1:0]  ONE_D = 1;

  // R11
  occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CAP_V);

  // R3
  spill_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid |=> occupancy == CAP_V);

  // R3
  spill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_valid |-> (spill_count != '0) && (spill_count <= occupancy));

  // R2
  call_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !call_err) |=> depth == $past(depth) + ONE_D);

  // R8
  call_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_err |=> $stable(occupancy) && $stable(depth) && $stable(total_spilled));

  // R9
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |-> depth == '0);

  // R9
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> $stable(depth) && $stable(total_reloaded));

  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spill_valid && reload_valid));

  // R6
  tot_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> total_spilled == $past(total_spilled) + {{(CNT_W-SZW){1'b0}}, $past(spill_count)});

  // R6
  tot_rl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> total_reloaded == $past(total_reloaded) + {{(CNT_W-SZW){1'b0}}, $past(reload_count)});

endmodule

bind rwin_ctrl rwin_ctrl_chk #(
  .CAPACITY(CAPACITY), .STACK_DEPTH(STACK_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .call_req(call_req),
  .spill_valid(spill_valid), .spill_count(spill_count),
  .reload_valid(reload_valid), .reload_count(reload_count),
  .call_err(call_err), .underflow_err(underflow_err),
  .occupancy(occupancy), .depth(depth),
  .total_spilled(total_spilled), .total_reloaded(total_reloaded)
);

// File: tb/rwin_ctrl_tb.sv
module rwin_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_req = 1'b0, ret_req = 1'b0;
  logic [7:0] call_size = '0;
  always #5 clk = ~clk;

  logic       sv0, rv0, ce0, ue0, sv1, rv1, ce1, ue1;
  logic [7:0] sc0, rc0, oc0;
  logic [6:0] sc1, rc1, oc1;
  logic [5:0] dp0, dp1;
  logic [31:0] ts0, tr0, ts1, tr1;

  rwin_ctrl #(.CAPACITY(128), .FIXED_MODE(1'b0), .STACK_DEPTH(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
    .call_size(call_size), .spill_valid(sv0), .spill_count(sc0),
    .reload_valid(rv0), .reload_count(rc0), .call_err(ce0), .underflow_err(ue0),
    .occupancy(oc0), .depth(dp0), .total_spilled(ts0), .total_reloaded(tr0));

  rwin_ctrl #(.CAPACITY(64), .FIXED_MODE(1'b1), .FIXED_SIZE(8), .STACK_DEPTH(32)) u_fix (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
    .call_size(call_size[6:0]), .spill_valid(sv1), .spill_count(sc1),
    .reload_valid(rv1), .reload_count(rc1), .call_err(ce1), .underflow_err(ue1),
    .occupancy(oc1), .depth(dp1), .total_spilled(ts1), .total_reloaded(tr1));

  typedef struct {
    int spv, spc, rlv, rlc, cer, uer, occ, dep;
    longint tsp, trl;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  int m_used[2], m_dep[2], m_stk[2][32], m_cap[2];
  longint m_tsp[2], m_trl[2];

  task automatic chk(string tag, int inst, string what, longint act, longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d %s actual=%0d expected=%0d", tag, inst, what, act, exp);
    end
  endtask

  function automatic exp_t model(int m, bit c, bit r, int sz);
    exp_t e;
    int s, need, rl, top;
    e.occ = m_used[m]; e.dep = m_dep[m]; e.tsp = m_tsp[m]; e.trl = m_trl[m];
    e.spv = 0; e.spc = 0; e.rlv = 0; e.rlc = 0; e.cer = 0; e.uer = 0;
    s = (m == 1) ? 8 : sz;
    if (c) begin
      if (s == 0 || s > m_cap[m] || m_dep[m] == 32) e.cer = 1;
      else begin
        need = m_used[m] + s - m_cap[m];
        if (need < 0) need = 0;
        e.spc = need; e.spv = (need > 0);
        m_stk[m][m_dep[m]] = s;
        m_dep[m]++;
        m_used[m] = m_used[m] + s - need;
        m_tsp[m] += need;
      end
    end else if (r) begin
      if (m_dep[m] == 0) e.uer = 1;
      else begin
        top = m_stk[m][m_dep[m]-1];
        m_used[m] -= top;
        m_dep[m]--;
        if (m_dep[m] > 0 && m_used[m] < m_stk[m][m_dep[m]-1]) begin
          rl = m_stk[m][m_dep[m]-1] - m_used[m];
          e.rlc = rl; e.rlv = 1;
          m_used[m] += rl;
          m_trl[m] += rl;
        end
      end
    end
    return e;
  endfunction

  task automatic op(bit c, bit r, int sz);
    @(negedge clk);
    call_req = c; ret_req = r; call_size = sz[7:0];
    q0.push_back(model(0, c, r, sz));
    q1.push_back(model(1, c, r, sz));
  endtask

  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #4;
      if (q0.size() > 0) begin
        e = q0.pop_front();
        chk("R3", 0, "spill_valid", sv0, e.spv);
        chk("R3", 0, "spill_count", sc0, e.spc);
        chk("R5", 0, "reload_valid", rv0, e.rlv);
        chk("R5", 0, "reload_count", rc0, e.rlc);
        chk("R8", 0, "call_err", ce0, e.cer);
        chk("R9", 0, "underflow_err", ue0, e.uer);
        chk("R2", 0, "occupancy", oc0, e.occ);
        chk("R4", 0, "depth", dp0, e.dep);
        chk("R6", 0, "total_spilled", ts0, e.tsp);
        chk("R6", 0, "total_reloaded", tr0, e.trl);
      end
      if (q1.size() > 0) begin
        e = q1.pop_front();
        chk("R7", 1, "spill_valid", sv1, e.spv);
        chk("R7", 1, "spill_count", sc1, e.spc);
        chk("R7", 1, "reload_valid", rv1, e.rlv);
        chk("R7", 1, "reload_count", rc1, e.rlc);
        chk("R7", 1, "call_err", ce1, e.cer);
        chk("R7", 1, "underflow_err", ue1, e.uer);
        chk("R7", 1, "occupancy", oc1, e.occ);
        chk("R7", 1, "depth", dp1, e.dep);
        chk("R7", 1, "total_spilled", ts1, e.tsp);
        chk("R7", 1, "total_reloaded", tr1, e.trl);
      end
    end
  end

  initial begin
    m_cap[0] = 128; m_cap[1] = 64;
    for (int m = 0; m < 2; m++) begin
      m_used[m] = 0; m_dep[m] = 0; m_tsp[m] = 0; m_trl[m] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    op(0, 0, 0);              // R1 reset state
    op(1, 0, 40);             // R2
    op(1, 0, 50);
    op(1, 0, 30);             // occupancy 120
    op(1, 0, 20);             // R3 spill 12
    op(1, 0, 100);            // R3 spill 100
    op(0, 1, 0);              // R4 no reload needed
    op(0, 1, 0);              // R5 partial reload 22
    op(0, 1, 0);              // R5 reload 50
    op(0, 1, 0);              // R5 reload 40
    op(0, 1, 0);              // R4 last frame
    op(0, 1, 0);              // R9 underflow
    op(1, 0, 0);              // R8 zero size
    op(1, 0, 129);            // R8 oversize
    op(1, 0, 128);            // R3 exact fit, no spill
    op(1, 1, 5);              // R10 call wins
    op(0, 1, 0);
    op(0, 1, 0);
    for (int i = 0; i < 33; i++) op(1, 0, 1);   // R8 stack full on last
    for (int i = 0; i < 33; i++) op(0, 1, 0);   // R9 on last
    op(1, 0, 64);
    op(1, 0, 65);             // R3 spill 1
    op(0, 1, 0);              // R5 reload 1
    op(0, 0, 0);              // R11 final state
    op(0, 0, 0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule